// File: doc/BRIEF.md
# Set-Associative Word Cache with MRU-Protected Random Replacement

This block holds recently used blocks of 16-bit words in a set-associative array. The block has one request port that takes a word address together with a read or write command. A hit answers in the next cycle. On a read miss the block raises a miss flag and goes busy. It then pulls the whole aligned block from a backing store, one word per cycle. The miss takes a fixed latency, and after it the requested word comes back with the hit flag set.

The replacement way is drawn from a 16-bit LFSR. The way that was most recently used in the set is never chosen: when the random draw lands on it, the next way up is taken instead. Writes are applied only to lines that are already resident. A write miss reports a miss and leaves the cache and the backing store alone. Lines are never written back, so a word written to the cache is lost once its line is evicted.

Top module: `mru_cache`

## Requirements
- R1: After reset no line is valid, so the first access to any address misses; every set's MRU pointer is way 0.
- R2: An accepted request (req_valid high while busy is low) produces rsp_valid exactly one cycle later. On a read hit rsp_hit is 1 and rsp_rdata holds the stored word.
- R3: An address is split into a word offset (the low log2(BLOCK) bits, BLOCK being 2, 4 or 8) and a block number (the remaining bits). The set is the block number modulo the set count, and the full block number is kept as the tag. Two blocks that share a set stay distinct.
- R4: A read miss gives rsp_valid with rsp_miss one cycle after the request and raises busy. While the line is still short of words, mem_req stays high with mem_addr = {block number, word counter}, and the counter steps from 0 to BLOCK-1 on each cycle where mem_valid is high.
- R5: When the backing store keeps up, the fill ends exactly MISS_LAT cycles after the miss response. At that point busy falls and rsp_valid and rsp_hit are high, with rsp_rdata holding the requested word. No other response appears during the fill.
- R6: A fill never replaces the set's MRU way. The filled way becomes MRU, and a read or write hit makes its way MRU. With two ways, the line touched last always survives the next fill in its set.
- R7: A write hit gives rsp_hit and changes only the addressed word. Later reads of that word return the written value until the line is evicted.
- R8: A write miss gives rsp_miss, does not raise busy, issues no mem_req and changes no cached word.
- R9: Requests presented while busy is high are ignored: they produce no response and change no cached word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| busy | output | 1 | Line fill in progress; requests ignored |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Hit, or fill completed |
| rsp_miss | output | 1 | Lookup missed |
| rsp_rdata | output | DW | Read data |
| mem_req | output | 1 | Fill word wanted |
| mem_addr | output | AW | Address of wanted fill word |
| mem_valid | input | 1 | Fill word delivered this cycle |
| mem_rdata | input | DW | Fill word |

## Verification
The assertions assume that mem_valid is raised only while mem_req is high, and that the backing store delivers the data for the mem_addr shown in that same cycle. The bench memory builds mem_valid combinationally from mem_req, sometimes gated at half rate, and it computes the data as a function of mem_addr. The fixed latency check relies on eight words arriving well inside MISS_LAT, which both rates satisfy. The stimulus stays inside an address window of a few blocks per set, so conflicts and evictions happen often.

// File: rtl/mru_cache.sv
module mru_cache #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int WORDS    = 256,
  parameter int WAYS     = 2,
  parameter int BLOCK    = 8,
  parameter int MISS_LAT = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic          rsp_miss,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int SETS = WORDS / BLOCK / WAYS;
  localparam int OFFB = $clog2(BLOCK);
  localparam int SETB = $clog2(SETS);
  localparam int WAYB = $clog2(WAYS);
  localparam int TAGW = AW - OFFB;
  localparam int LATW = $clog2(MISS_LAT + 1);
  localparam int DEPTH = SETS * WAYS * BLOCK;

  logic [TAGW-1:0] tag_q  [SETS][WAYS];
  logic [WAYS-1:0] vld_q  [SETS];
  logic [WAYB-1:0] mru_q  [SETS];
  logic [DW-1:0]   data_q [DEPTH];

  logic [15:0]     lfsr_q;
  logic [TAGW-1:0] fblk_q;
  logic [OFFB-1:0] foff_q;
  logic [WAYB-1:0] fway_q;
  logic [OFFB:0]   wcnt_q;
  logic [LATW-1:0] lat_q;

  wire [TAGW-1:0] blk = req_addr[AW-1:OFFB];
  wire [SETB-1:0] set = blk[SETB-1:0];
  wire [OFFB-1:0] off = req_addr[OFFB-1:0];
  wire [SETB-1:0] fset = fblk_q[SETB-1:0];

  logic [WAYS-1:0] hv;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hv[w] = vld_q[set][w] && (tag_q[set][w] == blk);
  end

  logic            hit;
  logic [WAYB-1:0] hit_way, cand;
  always_comb begin
    hit = 1'b0;
    hit_way = mru_q[set];
    cand = '0;
    for (int i = 0; i < WAYS; i++) begin
      cand = mru_q[set] + WAYB'(i);
      if (!hit && hv[cand]) begin
        hit = 1'b1;
        hit_way = cand;
      end
    end
  end

  wire [WAYB-1:0] rnd    = lfsr_q[WAYB-1:0];
  wire [WAYB-1:0] victim = (rnd == mru_q[set]) ? rnd + 1'b1 : rnd;

  wire accept    = req_valid && !busy;
  wire fill_word = mem_req && mem_valid;
  wire fill_done = busy && (wcnt_q == (OFFB+1)'(BLOCK)) && (lat_q == LATW'(MISS_LAT - 1));

  assign mem_req  = busy && (wcnt_q != (OFFB+1)'(BLOCK));
  assign mem_addr = {fblk_q, wcnt_q[OFFB-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q    <= 16'hACE1;
      busy      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_rdata <= '0;
      fblk_q    <= '0;
      foff_q    <= '0;
      fway_q    <= '0;
      wcnt_q    <= '0;
      lat_q     <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        mru_q[s] <= '0;
      end
    end else begin
      lfsr_q    <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      if (accept) begin
        rsp_valid <= 1'b1;
        if (hit) begin
          rsp_hit   <= 1'b1;
          rsp_rdata <= data_q[{set, hit_way, off}];
          mru_q[set] <= hit_way;
        end else begin
          rsp_miss <= 1'b1;
          if (!req_write) begin
            busy   <= 1'b1;
            fblk_q <= blk;
            foff_q <= off;
            fway_q <= victim;
            wcnt_q <= '0;
            lat_q  <= '0;
            vld_q[set][victim] <= 1'b0;
          end
        end
      end
      if (busy) begin
        if (lat_q != LATW'(MISS_LAT - 1)) lat_q <= lat_q + 1'b1;
        if (fill_word) wcnt_q <= wcnt_q + 1'b1;
        if (fill_done) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b1;
          rsp_rdata <= data_q[{fset, fway_q, foff_q}];
          vld_q[fset][fway_q] <= 1'b1;
          mru_q[fset] <= fway_q;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept && req_write && hit) data_q[{set, hit_way, off}] <= req_wdata;
    if (accept && !req_write && !hit) tag_q[set][victim] <= blk;
    if (busy && fill_word) data_q[{fset, fway_q, wcnt_q[OFFB-1:0]}] <= mem_rdata;
  end
endmodule

module mru_cache_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_write,
  input logic busy,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic rsp_miss,
  input logic mem_req
);
  // R2
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> rsp_valid);
  // R2
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit || rsp_miss) |-> rsp_valid && !(rsp_hit && rsp_miss));
  // R4
  read_miss_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && !req_write |=> (rsp_hit || busy));
  // R4
  fill_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  // R8
  write_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy && req_write |=> !busy);
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid |=> !rsp_miss);
  // R5
  fill_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid && rsp_hit);
endmodule

bind mru_cache mru_cache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .mem_req(mem_req)
);

// File: tb/test_mru_cache.sv
module test_mru_cache;
  localparam int MISS_LAT = 50;
  localparam int SETS = 16;
  localparam int BLOCK = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic busy, rsp_valid, rsp_hit, rsp_miss, mem_req, mem_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_rdata;
  logic throttle = 0, ph = 0;

  always #5 clk = ~clk;
  always @(posedge clk) ph <= ~ph;

  function automatic logic [15:0] memf(input logic [15:0] a);
    return 16'(a * 16'd40503 + 16'd1234);
  endfunction

  assign mem_valid = mem_req && (!throttle || ph);
  assign mem_rdata = memf(mem_addr);

  mru_cache i_mru_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_rdata(rsp_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata)
  );

  int checks = 0, fails = 0;
  int mru_blk [SETS];
  int oth_blk [SETS];
  bit wflag [1024];
  logic [15:0] wval [1024];

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic evict(input int b);
    if (b >= 0)
      for (int k = 0; k < BLOCK; k++) wflag[b*BLOCK+k] = 0;
  endtask

  task automatic access(input bit w, input logic [15:0] a, input logic [15:0] d);
    int b, s, n, k;
    bit exp_hit;
    logic [15:0] exp_d;
    b = int'(a) / BLOCK;
    s = b % SETS;
    exp_hit = (mru_blk[s] == b) || (oth_blk[s] == b);
    exp_d = wflag[a] ? wval[a] : memf(a);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid, "R2 rsp_valid", rsp_valid, 1);
    chk(rsp_hit == exp_hit, "R3 hit/miss by tag", rsp_hit, exp_hit);
    chk(rsp_miss == !exp_hit, "R6 miss flag", rsp_miss, !exp_hit);
    if (exp_hit) begin
      if (oth_blk[s] == b) begin
        oth_blk[s] = mru_blk[s];
        mru_blk[s] = b;
      end
      if (w) begin
        wflag[a] = 1; wval[a] = d;
      end else
        chk(rsp_rdata == exp_d, "R7 read data", rsp_rdata, exp_d);
    end else if (w) begin
      chk(!busy && !mem_req, "R8 write miss no fill", busy, 0);
    end else begin
      chk(busy, "R4 busy on read miss", busy, 1);
      n = 0; k = 0;
      forever begin
        req_valid = 1; req_write = 1; req_addr = 16'd0; req_wdata = 16'hDEAD;
        if (mem_valid) begin
          chk(mem_addr == 16'(b*BLOCK + k), "R4 fill address", mem_addr, b*BLOCK + k);
          k++;
        end
        @(negedge clk);
        n++;
        if (rsp_valid || n > 400) break;
      end
      req_valid = 0;
      chk(n == MISS_LAT, "R5 miss latency", n, MISS_LAT);
      chk(k == BLOCK, "R4 fill word count", k, BLOCK);
      chk(rsp_hit && !busy, "R5 fill completion", rsp_hit, 1);
      chk(rsp_rdata == exp_d, "R5 fill data", rsp_rdata, exp_d);
      evict(oth_blk[s]);
      oth_blk[s] = mru_blk[s];
      mru_blk[s] = b;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin mru_blk[s] = -1; oth_blk[s] = -1; end
    for (int a = 0; a < 1024; a++) wflag[a] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !rsp_valid && !mem_req, "R1 reset outputs", busy, 0);
    // R1 first accesses miss; R8 write miss on empty cache
    access(1, 16'd24, 16'h1111);
    access(0, 16'd24, 0);
    // R6 directed: blocks 3, 19, 35 share set 3
    access(0, 16'd152, 0);
    access(0, 16'd25, 0);
    access(0, 16'd280, 0);
    access(0, 16'd153, 0);
    // R7 write hit then read neighbours
    access(1, 16'd26, 16'hBEEF);
    access(0, 16'd26, 0);
    access(0, 16'd27, 0);
    // R9 stray writes to address 0 were ignored
    access(0, 16'd0, 0);
    access(0, 16'd0, 0);
    for (int i = 0; i < 400; i++) begin
      if (i == 200) throttle = 1;
      access(i % 4 == 1, 16'((i*37 + (i/7)*101) % 512), 16'(i*3 + 7));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule